// File: doc/BRIEF.md
# Interior Raster Window Fetcher

This block feeds a gradient-magnitude pipeline from an on-chip square frame buffer of `IMG_DIM`×`IMG_DIM` pixels. After a start pulse it walks every pixel that has a full 3×3 neighbourhood, skipping the outermost ring of the frame. It goes in row-major order and presents one complete 3×3 neighbourhood per clock as a single packed word, together with the 1-based number of the centre pixel in that walk.

The frame store is a register array with nine combinational read ports. The whole neighbourhood is therefore read in the cycle it is needed, and the walk never pauses. The frame is loaded through a plain synchronous write port. A run timer models the drain of a `PIPE_STAGES`-deep arithmetic pipeline behind the fetcher. It raises a one-cycle done pulse when the last window would leave that pipeline, and it exposes the start-to-done latency as a cycle count.

Top module: `raster_window_fetch`

## Requirements
- R1: After reset, `win_valid`, `busy` and `done` are low, and `cycle_count` and `win_index` are 0.
- R2: A start accepted while idle makes `win_valid` high from the next cycle on, for exactly (IMG_DIM−2)² consecutive cycles.
- R3: The j-th valid cycle after a start carries `win_index` = j. Its centre is interior pixel (r,c) with r=(j−1)/(IMG_DIM−2) and c=(j−1) mod (IMG_DIM−2), at frame address (r+1)·IMG_DIM+(c+1). A border pixel is never a centre.
- R4: Window slot s = 3·dr+dc (dr,dc in 0..2) occupies `win_data[8s+7:8s]` and holds the pixel at address centre+(dr−1)·IMG_DIM+(dc−1). Slot 0 is top-left, slot 4 is the centre, and slot 8 is bottom-right.
- R5: `done` is high for exactly one cycle: the cycle in which `cycle_count` equals (IMG_DIM−2)²+PIPE_STAGES−1. `busy` falls after that cycle.
- R6: In the j-th cycle after an accepted start, `cycle_count` equals j. After `done` it holds (IMG_DIM−2)²+PIPE_STAGES−1 until the next accepted start.
- R7: A start pulse while `busy` is high is ignored: the walk, the index sequence and the done timing continue unchanged.
- R8: A write with `wr_en` high stores `wr_data` at `wr_addr` on the clock edge. A later run restarts from index 1 and reflects the new frame contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Frame store write enable |
| wr_addr | input | AW | Frame store write address (row·IMG_DIM+col) |
| wr_data | input | PIX_W | Pixel value to write |
| start | input | 1 | Start pulse, accepted only when idle |
| win_valid | output | 1 | Window on `win_data` is valid this cycle |
| win_data | output | 9·PIX_W | Packed 3×3 neighbourhood |
| win_index | output | IW | 1-based interior pixel number of the window centre |
| busy | output | 1 | Run in progress, including the pipeline drain |
| done | output | 1 | One-cycle pulse when the last window has drained |
| cycle_count | output | CW | Cycles since the accepted start |

## Verification
The embedded properties check on every cycle the following:
- the valid window follows an accepted start one cycle later;
- scanning stops after the last interior pixel;
- the index stays in range and steps by one;
- the centre address always matches the row and column counters;
- done is a single pulse tied to the full latency;
- a start while busy does not disturb the count.

Only the bench scenarios can show that the nine slots carry the right pixel values in the right positions for given frame contents. The same holds for the row wrap at the end of each interior row, for re-running on a rewritten frame, and for the exact cycle in which each output changes.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  localparam int NTAPS = 9;

  function automatic int tap_row(input int s);
    return s / 3;
  endfunction

  function automatic int tap_col(input int s);
    return s % 3;
  endfunction
endpackage

// File: rtl/rwf_frame_store.sv
module rwf_frame_store #(
  parameter int IMG_DIM = 32,
  parameter int PIX_W   = 8,
  parameter int AW      = 10
) (
  input  logic                              clk,
  input  logic                              wr_en,
  input  logic [AW-1:0]                     wr_addr,
  input  logic [PIX_W-1:0]                  wr_data,
  input  logic [AW-1:0]                     centre,
  output logic [rwf_pkg::NTAPS*PIX_W-1:0]   window
);
  localparam int DEPTH = 1 << AW;

  logic [PIX_W-1:0] mem [DEPTH];

  // storage array: no reset, written only through the enable
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // nine parallel combinational reads around the centre
  for (genvar s = 0; s < rwf_pkg::NTAPS; s++) begin : g_tap
    localparam int DR = rwf_pkg::tap_row(s);
    localparam int DC = rwf_pkg::tap_col(s);
    logic [AW-1:0] rd_addr;
    assign rd_addr = centre + AW'(DR * IMG_DIM + DC) - AW'(IMG_DIM + 1);
    assign window[s*PIX_W +: PIX_W] = mem[rd_addr];
  end
endmodule

// File: rtl/rwf_scanner.sv
module rwf_scanner #(
  parameter int IMG_DIM = 32,
  parameter int AW      = 10,
  parameter int IW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          step,
  output logic [AW-1:0] centre,
  output logic [IW-1:0] index
);
  localparam int SPAN = IMG_DIM - 2;
  localparam int NWIN = SPAN * SPAN;
  localparam int PW   = (SPAN > 1) ? $clog2(SPAN) : 1;

  logic [PW-1:0] col_q, col_n, row_q, row_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [AW-1:0] ctr_q, ctr_n;
  logic          at_last, row_end;

  assign at_last = (idx_q == IW'(NWIN));
  assign row_end = (col_q == PW'(SPAN - 1));

  always_comb begin
    col_n = col_q;
    row_n = row_q;
    idx_n = idx_q;
    ctr_n = ctr_q;
    if (launch) begin
      col_n = '0;
      row_n = '0;
      idx_n = IW'(1);
      ctr_n = AW'(IMG_DIM + 1);
    end else if (step && !at_last) begin
      idx_n = idx_q + IW'(1);
      if (row_end) begin
        col_n = '0;
        row_n = row_q + PW'(1);
        ctr_n = ctr_q + AW'(3);
      end else begin
        col_n = col_q + PW'(1);
        ctr_n = ctr_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
      idx_q <= '0;
      ctr_q <= AW'(IMG_DIM + 1);
    end else if (launch || step) begin
      col_q <= col_n;
      row_q <= row_n;
      idx_q <= idx_n;
      ctr_q <= ctr_n;
    end
  end

  assign centre = ctr_q;
  assign index  = idx_q;

  // R3: the incremental centre address tracks the row/column counters
  p_centre_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (ctr_q == AW'((int'(row_q) + 1) * IMG_DIM + int'(col_q) + 1)));

  // R3: index stays within the interior pixel range while scanning
  p_index_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (idx_q >= IW'(1) && idx_q <= IW'(NWIN)));

  // R3: consecutive scan cycles advance the index by one
  p_index_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_last) |=> (idx_q == $past(idx_q) + IW'(1)));
endmodule

// File: rtl/rwf_run_timer.sv
module rwf_run_timer #(
  parameter int NWIN  = 900,
  parameter int TOTAL = 903,
  parameter int CW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          launch,
  output logic          scanning,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] LAST = CW'(TOTAL);
  localparam logic [CW-1:0] PRE  = CW'(TOTAL - 1);
  localparam logic [CW-1:0] SEND = CW'(NWIN);

  logic          busy_q, busy_n, done_q, done_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign launch = start && !busy_q;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    if (launch) begin
      busy_n = 1'b1;
      cnt_n  = CW'(1);
    end else if (busy_q) begin
      done_n = (cnt_q == PRE);
      if (cnt_q == LAST) busy_n = 1'b0;
      else               cnt_n  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      if (launch || busy_q) cnt_q <= cnt_n;
    end
  end

  assign scanning = busy_q && (cnt_q <= SEND);
  assign busy     = busy_q;
  assign done     = done_q;
  assign count    = cnt_q;

  // R2: valid windows begin the cycle after an accepted start
  p_valid_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> scanning);

  // R2: scanning stops after the last window
  p_scan_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == SEND) |=> !scanning);

  // R5: done only at full latency and only for one cycle
  p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (busy_q && cnt_q == LAST));
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: a start during a run does not restart the count
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/raster_window_fetch.sv
module raster_window_fetch #(
  parameter  int IMG_DIM     = 32,
  parameter  int PIX_W       = 8,
  parameter  int PIPE_STAGES = 4,
  localparam int AW          = $clog2(IMG_DIM * IMG_DIM),
  localparam int NWIN        = (IMG_DIM - 2) * (IMG_DIM - 2),
  localparam int TOTAL       = NWIN + PIPE_STAGES - 1,
  localparam int IW          = $clog2(NWIN + 1),
  localparam int CW          = $clog2(TOTAL + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [AW-1:0]                    wr_addr,
  input  logic [PIX_W-1:0]                 wr_data,
  input  logic                             start,
  output logic                             win_valid,
  output logic [rwf_pkg::NTAPS*PIX_W-1:0]  win_data,
  output logic [IW-1:0]                    win_index,
  output logic                             busy,
  output logic                             done,
  output logic [CW-1:0]                    cycle_count
);
  logic          launch, scanning;
  logic [AW-1:0] centre;

  rwf_run_timer #(.NWIN(NWIN), .TOTAL(TOTAL), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .launch(launch),
    .scanning(scanning), .busy(busy), .done(done), .count(cycle_count)
  );

  rwf_scanner #(.IMG_DIM(IMG_DIM), .AW(AW), .IW(IW)) u_scan (
    .clk(clk), .rst_n(rst_n), .launch(launch), .step(scanning),
    .centre(centre), .index(win_index)
  );

  rwf_frame_store #(.IMG_DIM(IMG_DIM), .PIX_W(PIX_W), .AW(AW)) u_frame (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .centre(centre), .window(win_data)
  );

  assign win_valid = scanning;
endmodule

// File: tb/tb_raster_window_fetch.sv
module tb_raster_window_fetch;
  localparam int N     = 8;
  localparam int K     = 4;
  localparam int AW    = 6;
  localparam int NW    = (N - 2) * (N - 2);
  localparam int TOT   = NW + K - 1;
  localparam int IW    = $clog2(NW + 1);
  localparam int CW    = $clog2(TOT + 1);

  // {cycle j after start, valid, index, count, done}
  localparam int NVEC = 9;
  localparam int VEC [NVEC][5] = '{
    '{1, 1, 1, 1, 0}, '{2, 1, 2, 2, 0}, '{6, 1, 6, 6, 0},
    '{7, 1, 7, 7, 0}, '{20, 1, 20, 20, 0}, '{36, 1, 36, 36, 0},
    '{37, 0, 36, 37, 0}, '{39, 0, 36, 39, 1}, '{40, 0, 36, 39, 0}};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, start = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          win_valid, busy, done;
  logic [71:0]   win_data;
  logic [IW-1:0] win_index;
  logic [CW-1:0] cycle_count;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  raster_window_fetch #(.IMG_DIM(N), .PIX_W(8), .PIPE_STAGES(K)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .win_valid(win_valid), .win_data(win_data), .win_index(win_index),
    .busy(busy), .done(done), .cycle_count(cycle_count));

  function automatic logic [7:0] pix(input int a, input int pat);
    if (pat == 0) return 8'((a * 37 + 11) & 255);
    return 8'((a ^ 8'h5A) & 255);
  endfunction

  function automatic logic [71:0] exp_win(input int idx, input int pat);
    int r, c, ctr;
    logic [71:0] w;
    r = (idx - 1) / (N - 2);
    c = (idx - 1) % (N - 2);
    ctr = (r + 1) * N + c + 1;
    for (int s = 0; s < 9; s++)
      w[s*8 +: 8] = pix(ctr + (s / 3 - 1) * N + (s % 3 - 1), pat);
    return w;
  endfunction

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load(input int pat);
    for (int a = 0; a < N * N; a++) begin
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = pix(a, pat);
      tick();
    end
    wr_en = 1'b0;
  endtask

  task automatic fire();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int j, nvalid;
    #5;
    // R1: reset state
    chk("R1 valid", 72'(win_valid), 72'(0));
    chk("R1 busy", 72'(busy), 72'(0));
    chk("R1 done", 72'(done), 72'(0));
    chk("R1 count", 72'(cycle_count), 72'(0));
    chk("R1 index", 72'(win_index), 72'(0));
    tick(); rst_n = 1'b1; tick();

    // table-driven run on pattern 0 (R2, R3, R4, R5, R6)
    load(0);
    fire(); j = 1;
    for (int v = 0; v < NVEC; v++) begin
      while (j < VEC[v][0]) begin tick(); j++; end
      chk("R2 valid", 72'(win_valid), 72'(VEC[v][1]));
      chk("R3 index", 72'(win_index), 72'(VEC[v][2]));
      chk("R6 count", 72'(cycle_count), 72'(VEC[v][3]));
      chk("R5 done", 72'(done), 72'(VEC[v][4]));
      chk("R5 busy", 72'(busy), 72'(j <= TOT));
      if (VEC[v][1] == 1) chk("R4 window", win_data, exp_win(VEC[v][2], 0));
    end

    // R8: rewrite frame, rerun, sweep every window
    load(1);
    fire(); nvalid = 0;
    for (int c = 1; c <= TOT + 2; c++) begin
      if (win_valid) begin
        nvalid++;
        chk("R8 index", 72'(win_index), 72'(nvalid));
        chk("R4 window", win_data, exp_win(nvalid, 1));
      end
      if (c == TOT + 1) chk("R6 hold", 72'(cycle_count), 72'(TOT));
      tick();
    end
    chk("R2 valid length", 72'(nvalid), 72'(NW));

    // R7: start while busy is ignored
    fire(); j = 1;
    while (j < 10) begin tick(); j++; end
    start = 1'b1; tick(); start = 1'b0; j++;
    chk("R7 index", 72'(win_index), 72'(11));
    chk("R7 count", 72'(cycle_count), 72'(11));
    while (j < TOT) begin tick(); j++; end
    chk("R7 done", 72'(done), 72'(1));
    chk("R7 count", 72'(cycle_count), 72'(TOT));
    tick();
    chk("R7 idle", 72'(busy), 72'(0));

    finish_up();
  end
endmodule